// File: doc/BRIEF.md
# Cache maintenance command controller

This block is the register-side front end of a shared second-level cache used by up to four harts. It holds a control word whose fields configure the cache arrays, prefetchers and RAM timing. Each hart gets its own maintenance command slot and line-index register, and a shared status word reports every hart's progress in a 4-bit nibble.

Software writes a command code into its hart's slot. Code 0x12 requests write-back-and-invalidate of every line. Code 0x02 requests invalidation of the single line named by that hart's line-index register. A sequencer takes pending slots in round-robin order and drives one line operation at a time to the cache arrays over a request/acknowledge handshake. When the last operation of a command completes, the issuing hart's nibble returns to idle. Software polls its nibble and treats any nonzero value as busy.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, cache_en_o is 0 and line_req_o is 0.
- R2: The control word at offset 0x08 keeps only bits 0, 6:3 and 13:8 of a write (mask 0x3F79); other bits read 0. Bit 0 drives cache_en_o, bits 4:3 ipf_depth_o, bits 6:5 dpf_depth_o, bits 9:8 tag_out_cyc_o, bit 10 tag_in_setup_o, bits 12:11 data_out_cyc_o, bit 13 data_in_setup_o.
- R3: Hart h's command register is at 0x40+16h and its line-index register is at 0x48+16h. The line-index register reads back its full written value. Offsets 0x00 and 0x10 through 0x38 and the command registers read 0.
- R4: The status word at 0x80 holds hart h's nibble at bits 4h+3:4h, with 0 = idle, 1 = processing and 2 = illegal. No other code ever appears.
- R5: With bit 0 of the control word set, a write of 0x12 or 0x02 to the command register of a hart that is not processing sets its nibble to 1 on the next cycle.
- R6: Any other code written under the same conditions sets the nibble to 2. It stays 2 until a valid code is written to that hart.
- R7: Command writes to a hart whose nibble is 1 are ignored.
- R8: While bit 0 of the control word is clear, command writes are ignored: the status stays unchanged and no line operation is issued.
- R9: A 0x12 command issues line operations with line_op_o = 1 (write back and invalidate) for indices 0 to NUM_LINES-1 in ascending order. It issues one per cycle in which line_req_o and line_ack_i are both high. line_req_o and line_idx_o hold steady until acknowledged.
- R10: A 0x02 command issues exactly one operation with line_op_o = 0 (invalidate). Its index is the low bits of the hart's line-index register when the command starts.
- R11: When several slots are pending, they are started in round-robin order, beginning with the hart after the one started last.
- R12: The cycle after a command's last handshake, the issuing hart's nibble reads 0. No line operation is requested while every nibble is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i (combinational) |
| cache_en_o | output | 1 | Cache enable |
| ipf_depth_o | output | 2 | Instruction prefetch depth |
| dpf_depth_o | output | 2 | Data prefetch depth |
| tag_out_cyc_o | output | 2 | Tag RAM output-cycle setting |
| tag_in_setup_o | output | 1 | Tag RAM input setup |
| data_out_cyc_o | output | 2 | Data RAM output-cycle setting |
| data_in_setup_o | output | 1 | Data RAM input setup |
| line_req_o | output | 1 | Line operation request |
| line_op_o | output | 1 | 1 = write back and invalidate, 0 = invalidate |
| line_idx_o | output | 4 | Line index of the request |
| line_ack_i | input | 1 | Line operation accepted |

## Verification
The checker assumes that the cache side acknowledges only sampled requests and that a processing nibble can clear only through a completed handshake. It also assumes that only a command write to a hart can move that hart's nibble out of the illegal state. The bench's acknowledge generator raises line_ack_i at a fixed cadence of every cycle or every other cycle, and it logs a completed operation only where request and acknowledge coincide. Register traffic is driven on falling edges and read back combinationally. Commands sent to other harts during a walk therefore queue without disturbing the walk in progress.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROC = 2'd1,
    ST_ILL  = 2'd2
  } slot_st_e;

  localparam logic [63:0] CMD_WBINV_ALL = 64'h12;
  localparam logic [63:0] CMD_INV_LINE  = 64'h02;
  localparam logic [63:0] CTRL_MASK     = 64'h3F79;
  localparam logic [7:0]  CTRL_OFF      = 8'h08;
  localparam logic [7:0]  STAT_OFF      = 8'h80;

  function automatic logic [7:0] cmd_off(input int h);
    return 8'h40 + 8'(h * 16);
  endfunction

  function automatic logic [7:0] line_off(input int h);
    return 8'h48 + 8'(h * 16);
  endfunction
endpackage

// File: rtl/cmc_slot.sv
module cmc_slot
  import cmc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [63:0] cmd_code_i,
  input  logic        done_i,
  output slot_st_e    st_o,
  output logic        op_all_o
);
  slot_st_e st_q;
  logic     all_q;
  logic     code_ok;

  assign code_ok = (cmd_code_i == CMD_WBINV_ALL) || (cmd_code_i == CMD_INV_LINE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      all_q <= 1'b0;
    end else if (done_i) begin
      st_q <= ST_IDLE;
    end else if (cmd_we_i && st_q != ST_PROC) begin
      st_q <= code_ok ? ST_PROC : ST_ILL;
      if (code_ok) all_q <= (cmd_code_i == CMD_WBINV_ALL);
    end
  end

  assign st_o     = st_q;
  assign op_all_o = all_q;
endmodule

// File: rtl/cmc_rr_arb.sv
module cmc_rr_arb #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             take_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] last_q;

  // search starts one past the last winner
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = last_q;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = (int'(last_q) + off) % N;
      if (!gnt_valid_o && req_i[cand]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= IDX_W'(N - 1);
    else if (take_i) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/cmc_walker.sv
module cmc_walker #(
  parameter int NUM_HARTS = 4,
  parameter int NUM_LINES = 16,
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HART_W-1:0] start_hart_i,
  input  logic              start_all_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              line_req_o,
  output logic              line_op_o,
  output logic [LINE_W-1:0] line_idx_o,
  output logic              done_o,
  output logic [HART_W-1:0] done_hart_o
);
  logic              busy_q, all_q, last;
  logic [HART_W-1:0] hart_q;
  logic [LINE_W-1:0] idx_q;

  assign last = !all_q || (idx_q == LINE_W'(NUM_LINES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      all_q  <= 1'b0;
      hart_q <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        all_q  <= start_all_i;
        hart_q <= start_hart_i;
        idx_q  <= start_all_i ? '0 : start_line_i;
      end
    end else if (ack_i) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign line_req_o  = busy_q;
  assign line_op_o   = all_q;
  assign line_idx_o  = idx_q;
  assign done_o      = busy_q && ack_i && last;
  assign done_hart_o = hart_q;
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
  import cmc_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int NUM_LINES = 16,
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              cache_en_o,
  output logic [1:0]        ipf_depth_o,
  output logic [1:0]        dpf_depth_o,
  output logic [1:0]        tag_out_cyc_o,
  output logic              tag_in_setup_o,
  output logic [1:0]        data_out_cyc_o,
  output logic              data_in_setup_o,
  output logic              line_req_o,
  output logic              line_op_o,
  output logic [LINE_W-1:0] line_idx_o,
  input  logic              line_ack_i
);
  logic [63:0]            ctrl_q;
  logic [63:0]            line_q [NUM_HARTS];
  slot_st_e               st     [NUM_HARTS];
  logic [NUM_HARTS-1:0]   pend, op_all;
  logic [4*NUM_HARTS-1:0] stat_w;
  logic                   gnt_valid, start, busy, done;
  logic [HART_W-1:0]      gnt_idx, done_hart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ctrl_q <= '0;
    else if (wr_en_i && addr_i == CTRL_OFF) ctrl_q <= wdata_i & CTRL_MASK;
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic cmd_we;
    assign cmd_we = wr_en_i && ctrl_q[0] && (addr_i == cmd_off(h));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               line_q[h] <= '0;
      else if (wr_en_i && addr_i == line_off(h)) line_q[h] <= wdata_i;
    end

    cmc_slot i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_we_i   (cmd_we),
      .cmd_code_i (wdata_i),
      .done_i     (done && done_hart == HART_W'(h)),
      .st_o       (st[h]),
      .op_all_o   (op_all[h])
    );

    assign pend[h]           = (st[h] == ST_PROC);
    assign stat_w[4*h +: 4]  = {2'b00, st[h]};
  end

  cmc_rr_arb #(.N(NUM_HARTS)) i_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (busy ? '0 : pend),
    .take_i      (start),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  assign start = gnt_valid && !busy;

  cmc_walker #(.NUM_HARTS(NUM_HARTS), .NUM_LINES(NUM_LINES)) i_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_hart_i (gnt_idx),
    .start_all_i  (op_all[gnt_idx]),
    .start_line_i (line_q[gnt_idx][LINE_W-1:0]),
    .ack_i        (line_ack_i),
    .busy_o       (busy),
    .line_req_o   (line_req_o),
    .line_op_o    (line_op_o),
    .line_idx_o   (line_idx_o),
    .done_o       (done),
    .done_hart_o  (done_hart)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFF) rdata_o = ctrl_q;
    if (addr_i == STAT_OFF) rdata_o = 64'(stat_w);
    for (int h = 0; h < NUM_HARTS; h++)
      if (addr_i == line_off(h)) rdata_o = line_q[h];
  end

  assign cache_en_o      = ctrl_q[0];
  assign ipf_depth_o     = ctrl_q[4:3];
  assign dpf_depth_o     = ctrl_q[6:5];
  assign tag_out_cyc_o   = ctrl_q[9:8];
  assign tag_in_setup_o  = ctrl_q[10];
  assign data_out_cyc_o  = ctrl_q[12:11];
  assign data_in_setup_o = ctrl_q[13];
endmodule

// File: rtl/cmc_chk.sv
module cmc_chk #(
  parameter int NUM_HARTS = 4,
  parameter int NUM_LINES = 16,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [7:0]             addr_i,
  input logic                   line_req_i,
  input logic                   line_ack_i,
  input logic [LINE_W-1:0]      line_idx_i,
  input logic [4*NUM_HARTS-1:0] stat_i
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_req_i && !line_ack_i |=> line_req_i && $stable(line_idx_i));

  // R12
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i == '0 |-> !line_req_i);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
    logic cmd_wr;
    assign cmd_wr = wr_en_i && (addr_i == 8'h40 + 8'(h * 16));

    // R4
    stat_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_i[4*h +: 4] != 4'd3 && stat_i[4*h+3 -: 2] == 2'b00);

    // R6
    ill_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_i[4*h +: 4] == 4'd2 && !cmd_wr |=> stat_i[4*h +: 4] == 4'd2);

    // R7
    proc_no_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_i[4*h +: 4] == 4'd1 && !(line_req_i && line_ack_i) |=> stat_i[4*h +: 4] == 4'd1);
  end
endmodule

bind cache_maint_ctrl cmc_chk #(.NUM_HARTS(NUM_HARTS), .NUM_LINES(NUM_LINES)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .line_req_i (line_req_o),
  .line_ack_i (line_ack_i),
  .line_idx_i (line_idx_o),
  .stat_i     (stat_w)
);

// File: tb/test_cache_maint_ctrl.sv
module test_cache_maint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        cache_en, tag_isu, data_isu, line_req, line_op, line_ack = 1'b0;
  logic [1:0]  ipf, dpf, tag_oc, data_oc;
  logic [3:0]  line_idx;

  int n_chk = 0, n_bad = 0;
  int ack_period = 1, ack_cnt = 0;
  int log_n = 0;
  int log_idx [256];
  logic log_op [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_maint_ctrl #(.NUM_HARTS(4), .NUM_LINES(NL)) i_cache_maint_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cache_en_o(cache_en), .ipf_depth_o(ipf), .dpf_depth_o(dpf),
    .tag_out_cyc_o(tag_oc), .tag_in_setup_o(tag_isu), .data_out_cyc_o(data_oc),
    .data_in_setup_o(data_isu), .line_req_o(line_req), .line_op_o(line_op),
    .line_idx_o(line_idx), .line_ack_i(line_ack)
  );

  // acknowledge generator and handshake logger
  initial forever begin
    @(negedge clk);
    ack_cnt++;
    line_ack = (ack_cnt % ack_period) == 0;
    if (line_req && line_ack && log_n < 256) begin
      log_idx[log_n] = int'(line_idx);
      log_op[log_n]  = line_op;
      log_n++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      bus_rd(8'h80, s);
      if (s == 64'h0) break;
    end
  endtask

  task automatic t_reset();
    logic [63:0] d;
    bus_rd(8'h08, d); chk("R1 ctrl", d, 64'h0);
    bus_rd(8'h80, d); chk("R1 status", d, 64'h0);
    chk("R1 en/req", {62'h0, cache_en, line_req}, 64'h0);
    bus_rd(8'h00, d); chk("R3 cfg reads 0", d, 64'h0);
    bus_rd(8'h20, d); chk("R3 0x20 reads 0", d, 64'h0);
  endtask

  task automatic t_ctrl();
    logic [63:0] d;
    bus_wr(8'h08, '1);
    bus_rd(8'h08, d); chk("R2 mask", d, 64'h3F79);
    bus_wr(8'h08, 64'h0000_2928);  // bits 3,5,8,11,13
    chk("R2 fields", {50'h0, data_isu, data_oc, tag_isu, tag_oc, dpf, ipf, cache_en},
        {50'h0, 1'b1, 2'b01, 1'b0, 2'b01, 2'b01, 2'b01, 1'b0});
    bus_wr(8'h68, 64'hDEAD_BEEF_0000_0005);
    bus_rd(8'h68, d); chk("R3 line readback", d, 64'hDEAD_BEEF_0000_0005);
    bus_rd(8'h60, d); chk("R3 cmd reads 0", d, 64'h0);
  endtask

  task automatic t_disabled();
    logic [63:0] d;
    bus_wr(8'h08, 64'h0);
    log_n = 0;
    bus_wr(8'h50, 64'h12);
    bus_rd(8'h80, d); chk("R8 status after cmd while disabled", d, 64'h0);
    repeat (10) @(negedge clk);
    chk("R8 no line ops", 64'(log_n), 64'h0);
  endtask

  task automatic t_illegal_then_line();
    logic [63:0] d;
    bus_wr(8'h08, 64'h1);
    bus_wr(8'h60, 64'h33);
    bus_rd(8'h80, d); chk("R6 illegal nibble", d, 64'h200);
    repeat (8) @(negedge clk);
    bus_rd(8'h80, d); chk("R6 illegal sticky", d, 64'h200);
    log_n = 0;
    bus_wr(8'h60, 64'h02);
    bus_rd(8'h80, d); chk("R5 processing", d, 64'h100);
    wait_idle();
    bus_rd(8'h80, d); chk("R12 idle after line op", d, 64'h0);
    chk("R10 one op", 64'(log_n), 64'h1);
    chk("R10 index", 64'(log_idx[0]), 64'd5);
    chk("R10 op invalidate", 64'(log_op[0]), 64'h0);
  endtask

  task automatic t_full_walk();
    logic [63:0] d;
    int bad = 0;
    ack_period = 1;
    log_n = 0;
    bus_wr(8'h40, 64'h12);
    bus_rd(8'h80, d); chk("R5 hart0 processing", d, 64'h1);
    wait_idle();
    chk("R9 walk length", 64'(log_n), 64'(NL));
    for (int i = 0; i < NL; i++)
      if (log_idx[i] != i || log_op[i] != 1'b1) bad++;
    chk("R9 walk order/op", 64'(bad), 64'h0);
  endtask

  task automatic t_round_robin();
    logic [63:0] d;
    int bad = 0;
    ack_period = 2;
    bus_wr(8'h48, 64'd11);
    bus_wr(8'h68, 64'd12);
    bus_wr(8'h78, 64'd13);
    log_n = 0;
    bus_wr(8'h50, 64'h12);
    bus_wr(8'h40, 64'h02);
    bus_wr(8'h60, 64'h02);
    bus_wr(8'h70, 64'h02);
    bus_wr(8'h50, 64'h55);
    bus_rd(8'h80, d); chk("R7 busy write ignored, all pending", d, 64'h1111);
    wait_idle();
    chk("R11 op count", 64'(log_n), 64'(NL + 3));
    for (int i = 0; i < NL; i++)
      if (log_idx[i] != i || log_op[i] != 1'b1) bad++;
    chk("R9 walk under slow ack", 64'(bad), 64'h0);
    chk("R11 order", {32'h0, 8'(log_idx[NL]), 8'(log_idx[NL+1]), 8'(log_idx[NL+2]), 8'h0},
        {32'h0, 8'd12, 8'd13, 8'd11, 8'h0});
    chk("R10 queued ops invalidate", 64'({log_op[NL], log_op[NL+1], log_op[NL+2]}), 64'h0);
    repeat (4) @(negedge clk);
    chk("R12 no request when idle", 64'(line_req), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_disabled();
    t_illegal_then_line();
    t_full_walk();
    t_round_robin();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule